// File: doc/BRIEF.md
# Lock-Guarded System Control Register Bank

This block is a small bank of system control registers on a simple 32-bit bus. The bus has a valid strobe, a write flag and a 12-bit byte offset. Read data is returned on the cycle after the request, and it reads as zero on every cycle that carries no read.

The bank holds a fixed board identity word and a fixed processor identity word, an LED register and two free configuration words. It has a volatile flag word and a non-volatile flag word, and each is changed through its own set address and its own clear address. Further registers are a display-control word, a card-status word driven by two pins, and a reset-control word. The reset-control word is guarded by an unlock register holding a 16-bit key, and it can request a system reset.

The board-type field, bits [27:16] of the identity parameter, is fixed at elaboration. It selects which registers are implemented, which bits are writable, and which data bit triggers a reset. The non-volatile flags are cleared only by a separate power-on reset, so they survive the ordinary reset.

Top module: `sysctl_regs`

## Requirements
- R1: While `rst_n` is low the LED, unlock, flag, reset-level and both configuration words become zero. The display word becomes 0x1F00, or 0 when the board type is 0x190.
- R2: A read presented with `bus_valid`=1 and `bus_write`=0 returns its data on `bus_rdata` one cycle later. On any cycle without a read, `bus_rdata` is zero. Unmapped offsets read zero and ignore writes.
- R3: A write to offset 0x20 stores data[15:0]. If the value is 0xA05F it is stored unchanged; otherwise bit 15 is stored as 0. Offset 0x20 reads back the stored 16-bit value.
- R4: Offset 0x30 reads the volatile flags. A write to 0x30 ORs the data in, and a write to 0x34 clears the bits that are set in the data. Offsets 0x38 (read and set) and 0x3C (clear) do the same for the non-volatile flags.
- R5: The non-volatile flags keep their value through `rst_n` and are cleared only by `por_n`.
- R6: A write to 0x40 stores the data as the reset level only while the unlock register holds 0xA05F, and only on board types 0x100, 0x178 and 0x182. Offset 0x40 reads the reset level on those boards and reads zero on every other board.
- R7: An accepted write to 0x40 raises `reset_req_o` for exactly one cycle, starting on the cycle after the write. The trigger is data bit 8 on board 0x100 and data bit 2 on boards 0x178 and 0x182.
- R8: Offset 0x48 reads `card_present_i` at bit 0 and `wprot_i` at bit 2 on boards 0x100 and 0x140, or at bit 1 on other boards. All other bits read zero.
- R9: On boards 0x100 and 0x140, a write to 0x50 replaces every bit except [13:8], which stay read-only. On every other board, writes to 0x50 are ignored.
- R10: On board 0x100, a write to 0x50 drives data[1:0] onto `disp_mux_o` from the next cycle. On other boards `disp_mux_o` stays 0.
- R11: Offset 0x00 reads the identity parameter, 0x84 reads the processor-ID parameter, 0x44 reads 1 and 0x88 reads 0xFF000000.
- R12: Offsets 0x08, 0x28 and 0x2C are plain 32-bit read/write registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for all state except the non-volatile flags |
| por_n | input | 1 | Active-low power-on reset for the non-volatile flags |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| card_present_i | input | 1 | Card-detect pin |
| wprot_i | input | 1 | Write-protect pin |
| reset_req_o | output | 1 | One-cycle reset request |
| disp_mux_o | output | 2 | Display format mux select |

## Verification
Read data, the reset pulse and the mux select all become visible one register stage after the bus cycle that caused them. The bench drives each request on a falling edge and samples results on the following falling edge. It checks one further falling edge to confirm the reset pulse has dropped. The status word is read combinationally from the pins during the request cycle, so the pins are set before the read is issued. Three instances with different board types share one bus, which lets every board-dependent rule be compared within a single request.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int AW = 12;
    localparam int DW = 32;
    localparam int KW = 16;

    localparam logic [KW-1:0] UNLOCK_KEY = 16'hA05F;

    localparam logic [11:0] BRD_926 = 12'h100;
    localparam logic [11:0] BRD_EB  = 12'h140;
    localparam logic [11:0] BRD_A8  = 12'h178;
    localparam logic [11:0] BRD_PBX = 12'h182;
    localparam logic [11:0] BRD_VX  = 12'h190;

    localparam logic [AW-1:0] OFS_IDENT  = 12'h000;
    localparam logic [AW-1:0] OFS_LED    = 12'h008;
    localparam logic [AW-1:0] OFS_LOCK   = 12'h020;
    localparam logic [AW-1:0] OFS_CFG1   = 12'h028;
    localparam logic [AW-1:0] OFS_CFG2   = 12'h02C;
    localparam logic [AW-1:0] OFS_FSET   = 12'h030;
    localparam logic [AW-1:0] OFS_FCLR   = 12'h034;
    localparam logic [AW-1:0] OFS_NVSET  = 12'h038;
    localparam logic [AW-1:0] OFS_NVCLR  = 12'h03C;
    localparam logic [AW-1:0] OFS_RSTCTL = 12'h040;
    localparam logic [AW-1:0] OFS_PCI    = 12'h044;
    localparam logic [AW-1:0] OFS_STAT   = 12'h048;
    localparam logic [AW-1:0] OFS_DISP   = 12'h050;
    localparam logic [AW-1:0] OFS_PROC0  = 12'h084;
    localparam logic [AW-1:0] OFS_PROC1  = 12'h088;

    localparam logic [DW-1:0] DISP_RO_MASK = 32'h0000_3F00;
    localparam logic [DW-1:0] DISP_RST     = 32'h0000_1F00;
    localparam logic [DW-1:0] PROC1_VAL    = 32'hFF00_0000;

    typedef struct packed {
        logic [DW-1:0] led;
        logic [DW-1:0] cfg1;
        logic [DW-1:0] cfg2;
        logic [DW-1:0] rstlvl;
        logic [DW-1:0] disp;
        logic [DW-1:0] rdata;
        logic          rstreq;
        logic [1:0]    mux;
    } ctl_state_t;

endpackage

// File: rtl/sysctl_lock.sv
module sysctl_lock
    import sysctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [KW-1:0] wdata,
    output logic [KW-1:0] lock_o,
    output logic          unlocked_o
);

    logic [KW-1:0] lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (wr_en) begin
            if (wdata == UNLOCK_KEY) lock_d = wdata;
            else                     lock_d = {1'b0, wdata[KW-2:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= '0;
        else        lock_q <= lock_d;
    end

    assign lock_o     = lock_q;
    assign unlocked_o = (lock_q == UNLOCK_KEY);

    // R3
    wrong_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata != UNLOCK_KEY) |=> !lock_o[KW-1]);
    // R3
    right_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata == UNLOCK_KEY) |=> unlocked_o);

endmodule

// File: rtl/sysctl_setclr.sv
module sysctl_setclr
    import sysctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_set,
    input  logic          wr_clr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] value_o
);

    logic [DW-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (wr_set) val_d = val_d | wdata;
        if (wr_clr) val_d = val_d & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign value_o = val_q;

    // R4
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && !wr_clr) |=> ((value_o & $past(wdata)) == $past(wdata)));
    // R4
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !wr_set) |=> ((value_o & $past(wdata)) == '0));

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter logic [31:0] BOARD_IDENT = 32'h4100_0101,
    parameter logic [31:0] PROC_IDENT  = 32'h0200_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_n,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          card_present_i,
    input  logic          wprot_i,
    output logic          reset_req_o,
    output logic [1:0]    disp_mux_o
);

    localparam logic [11:0] BRD      = BOARD_IDENT[27:16];
    localparam bit          IS_926   = (BRD == BRD_926);
    localparam bit          IS_EB    = (BRD == BRD_EB);
    localparam bit          RST_IMPL = IS_926 || (BRD == BRD_A8) || (BRD == BRD_PBX);
    localparam int          RST_BIT  = IS_926 ? 8 : 2;
    localparam bit          DISP_RW  = IS_926 || IS_EB;
    localparam int          WP_BIT   = (IS_926 || IS_EB) ? 2 : 1;
    localparam logic [DW-1:0] DISP_INIT = (BRD == BRD_VX) ? '0 : DISP_RST;

    logic wr, rd;
    assign wr = bus_valid &&  bus_write;
    assign rd = bus_valid && !bus_write;

    logic [KW-1:0] lock_val;
    logic          unlocked;
    logic [DW-1:0] flags, nvflags;

    sysctl_lock u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr && bus_addr == OFS_LOCK),
        .wdata      (bus_wdata[KW-1:0]),
        .lock_o     (lock_val),
        .unlocked_o (unlocked)
    );

    sysctl_setclr u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_set  (wr && bus_addr == OFS_FSET),
        .wr_clr  (wr && bus_addr == OFS_FCLR),
        .wdata   (bus_wdata),
        .value_o (flags)
    );

    sysctl_setclr u_nvflags (
        .clk     (clk),
        .rst_n   (por_n),
        .wr_set  (wr && bus_addr == OFS_NVSET),
        .wr_clr  (wr && bus_addr == OFS_NVCLR),
        .wdata   (bus_wdata),
        .value_o (nvflags)
    );

    ctl_state_t st_d, st_q;
    logic [DW-1:0] status_w;
    logic [DW-1:0] rd_mux;

    always_comb begin
        status_w         = '0;
        status_w[0]      = card_present_i;
        status_w[WP_BIT] = wprot_i;
    end

    always_comb begin
        unique case (bus_addr)
            OFS_IDENT:  rd_mux = BOARD_IDENT;
            OFS_LED:    rd_mux = st_q.led;
            OFS_LOCK:   rd_mux = {{(DW-KW){1'b0}}, lock_val};
            OFS_CFG1:   rd_mux = st_q.cfg1;
            OFS_CFG2:   rd_mux = st_q.cfg2;
            OFS_FSET:   rd_mux = flags;
            OFS_NVSET:  rd_mux = nvflags;
            OFS_RSTCTL: rd_mux = RST_IMPL ? st_q.rstlvl : '0;
            OFS_PCI:    rd_mux = 32'd1;
            OFS_STAT:   rd_mux = status_w;
            OFS_DISP:   rd_mux = st_q.disp;
            OFS_PROC0:  rd_mux = PROC_IDENT;
            OFS_PROC1:  rd_mux = PROC1_VAL;
            default:    rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.rstreq = 1'b0;
        st_d.rdata  = rd ? rd_mux : '0;
        if (wr) begin
            unique case (bus_addr)
                OFS_LED:  st_d.led  = bus_wdata;
                OFS_CFG1: st_d.cfg1 = bus_wdata;
                OFS_CFG2: st_d.cfg2 = bus_wdata;
                OFS_RSTCTL: begin
                    if (RST_IMPL && unlocked) begin
                        st_d.rstlvl = bus_wdata;
                        st_d.rstreq = bus_wdata[RST_BIT];
                    end
                end
                OFS_DISP: begin
                    if (DISP_RW) begin
                        st_d.disp = (st_q.disp & DISP_RO_MASK) | (bus_wdata & ~DISP_RO_MASK);
                    end
                    if (IS_926) st_d.mux = bus_wdata[1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.disp <= DISP_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata   = st_q.rdata;
    assign reset_req_o = st_q.rstreq;
    assign disp_mux_o  = st_q.mux;

    // R7
    rstreq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |=> !reset_req_o);
    // R7
    rstreq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> $past(wr && bus_addr == OFS_RSTCTL && unlocked));
    // R2
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd) |-> (bus_rdata == '0));
    // R10
    mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr && bus_addr == OFS_DISP) |-> $stable(disp_mux_o));

    generate
        if (DISP_RW) begin : g_disp_ro
            // R9
            disp_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $stable(st_q.disp[13:8]));
        end
    endgenerate

endmodule

// File: tb/test_sysctl_regs.sv
module test_sysctl_regs;

    localparam logic [31:0] ID_A = 32'h4100_0101;
    localparam logic [31:0] ID_B = 32'h1182_0000;
    localparam logic [31:0] ID_C = 32'h1190_0000;
    localparam logic [31:0] PID  = 32'h0200_0000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, por_n, bus_valid, bus_write, card, wp;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] rd_a, rd_b, rd_c;
    logic        rq_a, rq_b, rq_c;
    logic [1:0]  mx_a, mx_b, mx_c;

    sysctl_regs #(.BOARD_IDENT(ID_A), .PROC_IDENT(PID)) i_sysctl_regs (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rd_a), .card_present_i(card), .wprot_i(wp),
        .reset_req_o(rq_a), .disp_mux_o(mx_a));
    sysctl_regs #(.BOARD_IDENT(ID_B), .PROC_IDENT(PID)) i_sysctl_regs_b (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rd_b), .card_present_i(card), .wprot_i(wp),
        .reset_req_o(rq_b), .disp_mux_o(mx_b));
    sysctl_regs #(.BOARD_IDENT(ID_C), .PROC_IDENT(PID)) i_sysctl_regs_c (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rd_c), .card_present_i(card), .wprot_i(wp),
        .reset_req_o(rq_c), .disp_mux_o(mx_c));

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_led, m_cfg1, m_cfg2, m_flags, m_nv;
    logic [31:0] ra, rb, rc;
    logic        pa, pb, pc;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        pa = rq_a; pb = rq_b; pc = rq_c;
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(input logic [11:0] a);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(negedge clk);
        ra = rd_a; rb = rd_b; rc = rd_c;
        bus_valid = 0;
    endtask

    function automatic logic [31:0] exp_common(input logic [11:0] a);
        case (a)
            12'h008: return m_led;
            12'h028: return m_cfg1;
            12'h02C: return m_cfg2;
            12'h030: return m_flags;
            12'h038: return m_nv;
            default: return 32'h0;
        endcase
    endfunction

    task automatic rd_all(input string req, input logic [11:0] a, input logic [31:0] e);
        rd(a);
        chk(req, ra, e); chk(req, rb, e); chk(req, rc, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog actual=hang expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [11:0] a;
        int op;
        rst_n = 0; por_n = 0; bus_valid = 0; bus_write = 0;
        bus_addr = '0; bus_wdata = '0; card = 0; wp = 0;
        m_led = 0; m_cfg1 = 0; m_cfg2 = 0; m_flags = 0; m_nv = 0;
        d = $urandom(32'd17);
        repeat (3) @(negedge clk);
        rst_n = 1; por_n = 1;

        // R1 reset state, R11 identity
        rd(12'h000); chk("R11", ra, ID_A); chk("R11", rb, ID_B); chk("R11", rc, ID_C);
        rd(12'h050); chk("R1", ra, 32'h1F00); chk("R1", rb, 32'h1F00); chk("R1", rc, 32'h0);
        rd_all("R1", 12'h008, 0);
        rd_all("R1", 12'h020, 0);
        rd_all("R1", 12'h040, 0);
        chk("R10", {30'b0, mx_a}, 0);
        // R11 constants
        rd_all("R11", 12'h044, 32'd1);
        rd_all("R11", 12'h088, 32'hFF00_0000);
        rd_all("R11", 12'h084, PID);
        // R2 no read -> zero
        @(negedge clk); chk("R2", rd_a, 0);

        // R3 lock
        wr(12'h020, 32'h0000_FFFF); rd_all("R3", 12'h020, 32'h7FFF);
        // R6 locked write ignored
        wr(12'h040, 32'h0000_0104);
        chk("R6", {29'b0, pa, pb, pc}, 0);
        rd_all("R6", 12'h040, 0);
        wr(12'h020, 32'h1234_A05F); rd_all("R3", 12'h020, 32'hA05F);
        // R6/R7 unlocked
        wr(12'h040, 32'h0000_0104);
        chk("R7", {31'b0, pa}, 1); chk("R7", {31'b0, pb}, 1); chk("R7", {31'b0, pc}, 0);
        @(negedge clk); chk("R7", {29'b0, rq_a, rq_b, rq_c}, 0);
        rd(12'h040); chk("R6", ra, 32'h104); chk("R6", rb, 32'h104); chk("R6", rc, 0);
        wr(12'h040, 32'h0000_0100);
        chk("R7", {31'b0, pa}, 1); chk("R7", {31'b0, pb}, 0);
        wr(12'h040, 32'h0000_0004);
        chk("R7", {31'b0, pa}, 0); chk("R7", {31'b0, pb}, 1);

        // R8 status
        card = 1; wp = 0;
        rd_all("R8", 12'h048, 32'h1);
        card = 0; wp = 1;
        rd(12'h048); chk("R8", ra, 32'h4); chk("R8", rb, 32'h2); chk("R8", rc, 32'h2);

        // R9 / R10 display
        wr(12'h050, 32'hFFFF_FFFF);
        chk("R10", {30'b0, mx_a}, 3); chk("R10", {30'b0, mx_b}, 0); chk("R10", {30'b0, mx_c}, 0);
        rd(12'h050); chk("R9", ra, 32'hFFFF_DFFF); chk("R9", rb, 32'h1F00); chk("R9", rc, 0);
        wr(12'h050, 32'h0000_0002);
        chk("R10", {30'b0, mx_a}, 2);
        rd(12'h050); chk("R9", ra, 32'h1F02);

        // R2 unmapped
        wr(12'h010, 32'hDEAD_BEEF); rd_all("R2", 12'h010, 0);
        rd_all("R2", 12'hFFC, 0);

        // R4 / R12 random traffic
        for (int i = 0; i < 400; i++) begin
            op = int'($urandom_range(0, 9));
            d  = $urandom;
            case (op)
                0: begin wr(12'h008, d); m_led  = d; end
                1: begin wr(12'h028, d); m_cfg1 = d; end
                2: begin wr(12'h02C, d); m_cfg2 = d; end
                3: begin wr(12'h030, d); m_flags = m_flags | d; end
                4: begin wr(12'h034, d); m_flags = m_flags & ~d; end
                5: begin wr(12'h038, d); m_nv = m_nv | d; end
                6: begin wr(12'h03C, d); m_nv = m_nv & ~d; end
                7: begin
                    a = 12'h100 + 12'($urandom_range(0, 31) * 4);
                    if ($urandom_range(0, 1) == 1) wr(a, d);
                    else rd_all("R2", a, 0);
                end
                default: begin
                    case ($urandom_range(0, 4))
                        0: a = 12'h008; 1: a = 12'h028; 2: a = 12'h02C;
                        3: a = 12'h030; default: a = 12'h038;
                    endcase
                    rd_all((a >= 12'h030) ? "R4" : "R12", a, exp_common(a));
                end
            endcase
        end
        rd_all("R12", 12'h008, m_led);
        rd_all("R4", 12'h038, m_nv);

        // R5 non-volatile across rst_n
        wr(12'h038, 32'h0000_00F0); m_nv = m_nv | 32'hF0;
        wr(12'h030, 32'h0000_000F);
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
        rd_all("R1", 12'h030, 0);
        rd_all("R1", 12'h008, 0);
        rd_all("R1", 12'h028, 0);
        rd_all("R5", 12'h038, m_nv);
        @(negedge clk); por_n = 0; @(negedge clk); por_n = 1;
        rd_all("R5", 12'h038, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule